// File: doc/BRIEF.md
# Double-Buffered PWM Period Channel

This block is one 8-bit pulse-width channel with a small register write port. Software writes a period value and a duty value through the port. Each value first lands in a buffer and reaches the active latch that drives the counter and comparator only at a safe point. Those points are the end of the running period, a write to the counter, or any cycle in which the channel is disabled. The waveform therefore always shows either the old settings or the new ones, never a mix of the two.

A tick-enable input stands in for the prescaled channel clock: the counter moves only on cycles where it is high. In left-aligned mode the counter runs from 0 up to the period minus one and wraps. In center-aligned mode it climbs to the period value and falls back, so each output period is twice as long. The output is at its active level while the counter is below the active duty value. A polarity input sets which level counts as active.

The write port is a single-cycle strobe with no back-pressure: every write is accepted in the cycle it is presented, and no ready signal exists. Readback is combinational from the selected register.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: After reset, the period buffer, the duty buffer and the counter read 0, and the output sits at the inactive level.
- R2: While the channel is enabled, a write with wr_sel=0 (period) or wr_sel=1 (duty) changes only the buffer. The running waveform keeps the old active value until the counter returns to 0 at the end of the period.
- R3: A write with wr_sel=2 (counter) ignores its data. It clears the counter to 0 on the next edge and loads both buffered values into the active latches.
- R4: Every cycle in which ch_en is low clears the counter and copies both buffers into the active latches, so a write made while disabled takes effect at once.
- R5: rd_data returns, combinationally, the period buffer for rd_sel=0, the duty buffer for rd_sel=1, the counter for rd_sel=2 and 0 for rd_sel=3. The buffers always show the last value written.
- R6: In left-aligned mode (center_mode=0) with active period P>0, the counter steps 0,1,…,P-1 and then wraps, giving an output period of P ticks.
- R7: In center-aligned mode (center_mode=1) with P>0, the counter steps 0,1,…,P,P-1,…,1 and then returns to 0, giving an output period of 2·P ticks.
- R8: With the channel enabled and P>0, the output is at the active level when the counter is below the active duty value D, or when D≥P. Otherwise it is at the inactive level. The active level is high when polarity=1 and low when polarity=0.
- R9: With active period 0, the counter stays at 0 and the output stays at the inactive level.
- R10: While enabled, the counter holds its value on any cycle with tick_en low, unless a counter write clears it.
- R11: While ch_en is low, the output is at the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | 1 | Channel enable |
| tick_en | input | 1 | Channel clock enable; counter advances when high |
| center_mode | input | 1 | 0 left-aligned, 1 center-aligned |
| polarity | input | 1 | 1: active level high; 0: active level low |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 period, 1 duty, 2 counter |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read select: 0 period, 1 duty, 2 counter, 3 zero |
| rd_data | output | 8 | Readback value |
| pwm_out | output | 1 | PWM output |

## Verification
A table of period, duty, alignment and polarity settings runs the channel for exactly one output period each. The patterns include duty below period, duty equal to or above period, duty zero, the period values 0 and 1, and inverted polarity. For each pattern the bench counts the active samples and the counter zeros. This separates a wrong compare threshold from a wrong period length, and a left-aligned count from a center-aligned one. Directed sequences then write new values partway through a period. They distinguish an immediate update from a deferred one by watching which counter value comes just before the wrap, and they do this separately for period-end, counter-write and disable loads.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/pwm_shadow_reg.sv
// Buffer plus active latch; the active latch takes the post-write buffer value on load.
module pwm_shadow_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] buf_q,
  output logic [W-1:0] act_q
);
  logic [W-1:0] buf_next;

  assign buf_next = wr ? wdata : buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      buf_q <= buf_next;
      if (load) act_q <= buf_next;
    end
  end
endmodule

// File: rtl/pwm_updown_counter.sv
// Channel counter: wraps in left-aligned mode, bounces in center-aligned mode.
module pwm_updown_counter
  import pwm_dbuf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         clear,
  input  logic         center,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt_q,
  output logic         period_end
);
  localparam logic [W-1:0] ONE = W'(1);

  cnt_dir_e     dir_q, dir_n;
  logic [W-1:0] cnt_n;

  always_comb begin
    if (period == '0) begin
      cnt_n = '0;
    end else if (!center) begin
      cnt_n = (cnt_q >= period - ONE) ? '0 : cnt_q + ONE;
    end else if (dir_q == DIR_UP && cnt_q < period) begin
      cnt_n = cnt_q + ONE;
    end else begin
      cnt_n = cnt_q - ONE;
    end

    if (cnt_n == '0 || !center)
      dir_n = DIR_UP;
    else if (dir_q == DIR_UP && cnt_q >= period)
      dir_n = DIR_DOWN;
    else
      dir_n = dir_q;
  end

  assign period_end = run && !clear && tick && (cnt_n == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (!run || clear) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (tick) begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
    end
  end
endmodule

// File: rtl/pwm_level_gen.sv
// Output compare and polarity.
module pwm_level_gen #(
  parameter int W = 8
) (
  input  logic         run,
  input  logic         polarity,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] period,
  input  logic [W-1:0] duty,
  output logic         level
);
  logic active;

  always_comb begin
    if (!run || period == '0)
      active = 1'b0;
    else
      active = (duty >= period) || (cnt < duty);
  end

  assign level = active ? polarity : ~polarity;
endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel
  import pwm_dbuf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ch_en,
  input  logic         tick_en,
  input  logic         center_mode,
  input  logic         polarity,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic         pwm_out
);
  reg_sel_e     wsel, rsel;
  logic         per_wr, duty_wr, cnt_wr;
  logic         period_end, latch_load;
  logic [W-1:0] per_buf, per_act, duty_buf, duty_act, cnt_q;

  assign wsel    = reg_sel_e'(wr_sel);
  assign rsel    = reg_sel_e'(rd_sel);
  assign per_wr  = wr_en && (wsel == SEL_PERIOD);
  assign duty_wr = wr_en && (wsel == SEL_DUTY);
  assign cnt_wr  = wr_en && (wsel == SEL_COUNT);

  // Safe points for a latch update: disabled, counter write, period boundary.
  assign latch_load = !ch_en || cnt_wr || period_end;

  pwm_shadow_reg #(.W(W)) i_per (
    .clk(clk), .rst_n(rst_n), .wr(per_wr), .wdata(wr_data),
    .load(latch_load), .buf_q(per_buf), .act_q(per_act)
  );

  pwm_shadow_reg #(.W(W)) i_duty (
    .clk(clk), .rst_n(rst_n), .wr(duty_wr), .wdata(wr_data),
    .load(latch_load), .buf_q(duty_buf), .act_q(duty_act)
  );

  pwm_updown_counter #(.W(W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .run(ch_en), .tick(tick_en),
    .clear(cnt_wr), .center(center_mode), .period(per_act),
    .cnt_q(cnt_q), .period_end(period_end)
  );

  pwm_level_gen #(.W(W)) i_lvl (
    .run(ch_en), .polarity(polarity), .cnt(cnt_q),
    .period(per_act), .duty(duty_act), .level(pwm_out)
  );

  always_comb begin
    unique case (rsel)
      SEL_PERIOD: rd_data = per_buf;
      SEL_DUTY:   rd_data = duty_buf;
      SEL_COUNT:  rd_data = cnt_q;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pwm_dbuf_checker.sv
module pwm_dbuf_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ch_en,
  input logic         tick_en,
  input logic         center_mode,
  input logic         polarity,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] per_buf,
  input logic [W-1:0] per_act,
  input logic [W-1:0] cnt_q,
  input logic         pwm_out
);
  // R2: active period moves only when the counter is back at 0 or after a disabled cycle
  assert_period_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(per_act) |-> (cnt_q == '0 || !$past(ch_en)));

  // R3: counter write clears the counter
  assert_cnt_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> (cnt_q == '0));

  // R5: period buffer shows the last written value
  assert_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> (per_buf == $past(wr_data)));

  // R6: left-aligned counter stays below the period
  assert_left_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && !center_mode && per_act != '0 && cnt_q < per_act)
      |=> (center_mode || per_act == '0 || cnt_q < per_act));

  // R7: center-aligned counter never passes the period
  assert_center_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && center_mode) |-> (cnt_q <= per_act));

  // R10: no tick, no movement
  assert_tick_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && !tick_en && !(wr_en && wr_sel == 2'd2)) |=> $stable(cnt_q));

  // R11: disabled channel sits at the inactive level
  assert_idle_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |-> (pwm_out == !polarity));
endmodule

bind pwm_dbuf_channel pwm_dbuf_checker #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .tick_en(tick_en),
  .center_mode(center_mode), .polarity(polarity), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_data(wr_data), .per_buf(per_buf),
  .per_act(per_act), .cnt_q(cnt_q), .pwm_out(pwm_out)
);

// File: tb/test_pwm_dbuf_channel.sv
`timescale 1ns/10ps
module test_pwm_dbuf_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ch_en = 1'b0, tick_en = 1'b0, center_mode = 1'b0, polarity = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0, rd_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       pwm_out;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_dbuf_channel #(.W(8)) i_pwm_dbuf_channel (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .tick_en(tick_en),
    .center_mode(center_mode), .polarity(polarity), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .pwm_out(pwm_out)
  );

  typedef struct packed {
    logic [7:0] per;
    logic [7:0] duty;
    logic       ctr;
    logic       pol;
    logic [7:0] len;
    logic [7:0] highs;
    logic [7:0] zeros;
  } vec_t;

  // expected values worked out from R6..R9
  localparam vec_t VECS [9] = '{
    '{8'd10, 8'd3, 1'b0, 1'b1, 8'd10, 8'd3,  8'd1},
    '{8'd10, 8'd3, 1'b0, 1'b0, 8'd10, 8'd7,  8'd1},
    '{8'd8,  8'd8, 1'b0, 1'b1, 8'd8,  8'd8,  8'd1},
    '{8'd6,  8'd0, 1'b0, 1'b1, 8'd6,  8'd0,  8'd1},
    '{8'd5,  8'd2, 1'b1, 1'b1, 8'd10, 8'd3,  8'd1},
    '{8'd4,  8'd9, 1'b1, 1'b1, 8'd8,  8'd8,  8'd1},
    '{8'd3,  8'd1, 1'b1, 1'b0, 8'd6,  8'd5,  8'd1},
    '{8'd1,  8'd0, 1'b1, 1'b1, 8'd2,  8'd0,  8'd1},
    '{8'd0,  8'd5, 1'b0, 1'b1, 8'd4,  8'd0,  8'd4}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output int v);
    rd_sel = sel;
    #0.1;
    v = int'(rd_data);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    step(2);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(2'd0, v); check("R1 period buf", v, 0);
    rd(2'd1, v); check("R1 duty buf", v, 0);
    rd(2'd2, v); check("R1 counter", v, 0);
    check("R1 output inactive", pwm_out, 0);
    rd(2'd3, v); check("R5 unused select", v, 0);

    // table walk
    foreach (VECS[i]) begin
      int highs, zeros;
      ch_en = 1'b0; tick_en = 1'b0;
      wr(2'd0, VECS[i].per);
      wr(2'd1, VECS[i].duty);
      center_mode = VECS[i].ctr; polarity = VECS[i].pol;
      ch_en = 1'b1; tick_en = 1'b1; rd_sel = 2'd2;
      highs = 0; zeros = 0;
      for (int k = 0; k < int'(VECS[i].len); k++) begin
        #0.1;
        if (pwm_out) highs++;
        if (rd_data == 8'd0) zeros++;
        step(1);
      end
      check($sformatf("R8 vec%0d active samples", i), highs, int'(VECS[i].highs));
      check($sformatf("R6/R7/R9 vec%0d zeros", i), zeros, int'(VECS[i].zeros));
      rd(2'd2, v); check($sformatf("R6 R7 vec%0d wrap", i), v, 0);
    end

    // R11 disabled output with low-active polarity
    ch_en = 1'b0; polarity = 1'b0; center_mode = 1'b0;
    step(1); #0.1;
    check("R11 idle level", pwm_out, 1);
    polarity = 1'b1;

    // R2 period buffered while enabled
    wr(2'd0, 8'd10); wr(2'd1, 8'd0);
    ch_en = 1'b1; tick_en = 1'b1;
    step(3);
    wr(2'd0, 8'd4);
    rd(2'd0, v); check("R5 readback new period", v, 4);
    step(5); rd(2'd2, v); check("R2 old period still active", v, 9);
    step(1); rd(2'd2, v); check("R2 wrap at old end", v, 0);
    step(3); rd(2'd2, v); check("R2 new period count", v, 3);
    step(1); rd(2'd2, v); check("R2 new period wrap", v, 0);

    // R3 counter write loads buffer
    wr(2'd0, 8'd7);
    step(1);
    wr(2'd2, 8'hAA);
    rd(2'd2, v); check("R3 counter cleared", v, 0);
    step(6); rd(2'd2, v); check("R3 loaded period", v, 6);
    step(1); rd(2'd2, v); check("R3 wrap at 7", v, 0);

    // R4 disable loads buffer
    wr(2'd0, 8'd3);
    ch_en = 1'b0; step(1);
    rd(2'd2, v); check("R4 counter cleared", v, 0);
    ch_en = 1'b1;
    step(2); rd(2'd2, v); check("R4 period 3 count", v, 2);
    step(1); rd(2'd2, v); check("R4 period 3 wrap", v, 0);

    // R10 tick gating
    step(1);
    tick_en = 1'b0; step(5);
    rd(2'd2, v); check("R10 counter held", v, 1);
    tick_en = 1'b1;

    // R2 duty buffered while enabled
    ch_en = 1'b0;
    wr(2'd0, 8'd10); wr(2'd1, 8'd2);
    ch_en = 1'b1;
    step(3);
    wr(2'd1, 8'd8);
    #0.1; check("R2 old duty at count 4", pwm_out, 0);
    step(6); rd(2'd2, v); check("R2 duty wrap", v, 0);
    step(5); #0.1; check("R8 new duty at count 5", pwm_out, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule